// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block collects single-cycle event pulses from the functions of a full-speed host controller. Those functions are frame timing, list processing, the root hub and ownership handover. The block latches each pulse into a sticky status bit and combines the latched bits into one active-high interrupt request. Software reads the latched causes through a small word-addressed register port. It acknowledges a cause by writing a one to its bit.

The per-source enable mask has no write port of its own. It is reached through two addresses. Ones written to the arm address set mask bits. Ones written to the disarm address clear them. Zeros written to either address change nothing, so software never needs a read-modify-write. Bit 31 of the mask is a global gate: no source raises the request while it is clear. Reads from both mask addresses return the same mask value.

The register map at the `addr_i` word index is:
- 0: status
- 1: arm (mask set)
- 2: disarm (mask clear)
- 3: unused

Top module: `irq_unit`

## Requirements
- R1: While reset is asserted and right after it is released, status and mask read as zero and `irq_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit P(k), where P = {0,1,2,3,4,5,6,30} for k = 0..7. The bit reads as 1 at address 0 from the next cycle on.
- R3: Writing to address 0 clears each status bit written as 1. Status bits written as 0 are left as they are.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Writing to address 1 sets each implemented mask bit written as 1. Those are bits P(k) and bit 31. Mask bits written as 0 are left as they are.
- R6: Writing to address 2 clears each mask bit written as 1. Mask bits written as 0 are left as they are.
- R7: Reads at address 1 and at address 2 both return the current mask.
- R8: `irq_o` is 1 exactly when mask bit 31 is 1 and some status bit is 1 whose mask bit is also 1. It follows register changes from the cycle after the write or the pulse.
- R9: Unimplemented bits read as 0, and status bit 31 is always 0. Address 3 reads as 0, and writes to it change no state.
- R10: While mask bit 31 is 0, `irq_o` stays 0 even when an armed status bit is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word index: 0 status, 1 arm, 2 disarm, 3 unused |
| wdata_i | input | 32 | Write data |
| evt_i | input | 8 | Single-cycle event pulses, in source order k = 0..7 |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a pulse and an acknowledge that hit the same status bit in the same cycle, because the bench must line the event input up with the write strobe on one edge. A directed phase does this for a single source and then for every source together. A random phase drives events and acknowledge writes independently every cycle, so the two collide again and again on mixed bits. That random phase also toggles the global gate while causes are pending, to show that disarming it hides the request and keeps the latched causes.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int NUM_SRC = 8;
    localparam int GATE_POS = 31;

    // bit position of each event source in status and mask
    localparam int SRC_POS [NUM_SRC] = '{0, 1, 2, 3, 4, 5, 6, 30};

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT = 2'd0,
        ADR_ARM  = 2'd1,
        ADR_DARM = 2'd2,
        ADR_RSVD = 2'd3
    } reg_adr_e;

    function automatic logic [DATA_W-1:0] src_bits();
        logic [DATA_W-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_SRC; k++) v[SRC_POS[k]] = 1'b1;
        return v;
    endfunction

    localparam logic [DATA_W-1:0] STAT_IMPL = src_bits();
    localparam logic [DATA_W-1:0] MASK_IMPL = src_bits() | (DATA_W'(1) << GATE_POS);

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } word_st_t;

endpackage

// File: rtl/intr_status_bank.sv
module intr_status_bank
    import irq_unit_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NUM_SRC
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] stat;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] evt_vec;

    always_comb begin
        evt_vec = '0;
        for (int k = 0; k < N; k++) evt_vec[SRC_POS[k]] = evt_i[k];
        st_d      = st_q;
        // acknowledge first, then events so a colliding pulse survives
        st_d.stat = ((st_q.stat & ~ack_i) | evt_vec) & STAT_IMPL[W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;

endmodule

// File: rtl/intr_mask_bank.sv
module intr_mask_bank
    import irq_unit_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] arm_i,
    input  logic [W-1:0] disarm_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mask = (st_q.mask | (arm_i & MASK_IMPL[W-1:0])) & ~disarm_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/intr_req_gen.sv
module intr_req_gen
    import irq_unit_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int GATE = GATE_POS
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    localparam logic [W-1:0] SRC_ONLY = ~(W'(1) << GATE);

    logic pend;

    always_comb begin
        pend  = |(stat_i & mask_i & SRC_ONLY);
        irq_o = mask_i[GATE] & pend;
    end

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_unit_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W,
    parameter int N  = NUM_SRC
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [N-1:0]  evt_i,
    output logic [W-1:0]  rdata_o,
    output logic          irq_o
);

    logic [W-1:0] ack_w, arm_w, disarm_w;
    logic [W-1:0] stat_w, mask_w;

    always_comb begin
        ack_w    = (wr_en_i && addr_i == ADR_STAT) ? wdata_i : '0;
        arm_w    = (wr_en_i && addr_i == ADR_ARM)  ? wdata_i : '0;
        disarm_w = (wr_en_i && addr_i == ADR_DARM) ? wdata_i : '0;
    end

    intr_status_bank #(.W(W), .N(N)) u_stat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i),
        .ack_i  (ack_w),
        .stat_o (stat_w)
    );

    intr_mask_bank #(.W(W)) u_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .arm_i    (arm_w),
        .disarm_i (disarm_w),
        .mask_o   (mask_w)
    );

    intr_req_gen #(.W(W), .GATE(GATE_POS)) u_req (
        .stat_i (stat_w),
        .mask_i (mask_w),
        .irq_o  (irq_o)
    );

    always_comb begin
        unique case (addr_i)
            ADR_STAT: rdata_o = stat_w;
            ADR_ARM,
            ADR_DARM: rdata_o = mask_w;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
    import irq_unit_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [1:0]        addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [DATA_W-1:0] stat_i,
    input logic [DATA_W-1:0] mask_i,
    input logic              irq_i
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk_i) !rst_ni |=> (!irq_i && stat_i == '0 && mask_i == '0));

    // R8
    req_needs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_i |-> mask_i[GATE_POS]);

    // R8
    req_needs_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_i |-> (stat_i & mask_i) != '0);

    // R9
    stat_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (stat_i & ~STAT_IMPL) == '0);

    // R9
    rsvd_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd3 && evt_i == '0) |=> ($stable(stat_i) && $stable(mask_i)));

    // R5
    gate_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd1 && wdata_i[GATE_POS]) |=> mask_i[GATE_POS]);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        localparam int P = SRC_POS[k];

        // R2 and R4: a pulse always lands, even against an acknowledge
        evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) evt_i[k] |=> stat_i[P]);

        // R3
        ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && addr_i == 2'd0 && wdata_i[P] && !evt_i[k]) |=> !stat_i[P]);

        // R5
        arm_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && addr_i == 2'd1 && wdata_i[P]) |=> mask_i[P]);

        // R6
        disarm_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && addr_i == 2'd2 && wdata_i[P]) |=> !mask_i[P]);
    end

endmodule

bind irq_unit irq_unit_chk chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .evt_i   (evt_i),
    .stat_i  (stat_w),
    .mask_i  (mask_w),
    .irq_i   (irq_o)
);

// File: tb/irq_unit_tb_top.sv
module irq_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [31:0] wdata_i = '0;
    logic [7:0]  evt_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string phase = "R1";

    // behavioural reference state
    bit [31:0] m_stat = '0;
    bit [31:0] m_mask = '0;
    bit [1:0]  m_addr = '0;
    int        pos_tab [8] = '{0, 1, 2, 3, 4, 5, 6, 30};

    always #2 clk_i = ~clk_i;

    irq_unit dut_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .evt_i   (evt_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_read(bit [1:0] a);
        case (a)
            2'd0:       return m_stat;
            2'd1, 2'd2: return m_mask;
            default:    return 32'h0;
        endcase
    endfunction

    function automatic bit exp_irq();
        bit any;
        any = 0;
        for (int k = 0; k < 8; k++) if (m_stat[pos_tab[k]] && m_mask[pos_tab[k]]) any = 1;
        return m_mask[31] && any;
    endfunction

    // one cycle: compare at the falling edge, then drive and advance model
    task automatic cyc(bit w, bit [1:0] a, bit [31:0] d, bit [7:0] e);
        bit [31:0] ev;
        @(negedge clk_i);
        check(rdata_o == exp_read(m_addr), phase, rdata_o, exp_read(m_addr));
        check(irq_o == exp_irq(), (phase == "R10") ? "R10" : "R8", 32'(irq_o), 32'(exp_irq()));
        wr_en_i = w; addr_i = a; wdata_i = d; evt_i = e;
        ev = '0;
        for (int k = 0; k < 8; k++) ev[pos_tab[k]] = e[k];
        if (w && a == 2'd0) m_stat = m_stat & ~d;
        m_stat = m_stat | ev;
        if (w && a == 2'd1) m_mask = m_mask | (d & 32'hC000_007F);
        if (w && a == 2'd2) m_mask = m_mask & ~d;
        m_addr = a;
    endtask

    task automatic rd(bit [1:0] a);
        cyc(0, a, 32'h0, 8'h0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk_i);
        for (int a = 0; a < 3; a++) begin
            addr_i = 2'(a);
            #0.5;
            check(rdata_o == 32'h0, "R1", rdata_o, 32'h0);
        end
        check(irq_o == 1'b0, "R1", 32'(irq_o), 32'h0);
        addr_i = 2'd0;
        rst_ni = 1'b1;
        rd(0); rd(1);

        // R2: each source lands on its own bit
        phase = "R2";
        for (int k = 0; k < 8; k++) begin
            cyc(0, 0, 0, 8'(1 << k));
            rd(0);
        end

        // R3: acknowledge with ones and zeros
        phase = "R3";
        cyc(1, 0, 32'h0000_0000, 8'h0); rd(0);
        cyc(1, 0, 32'h4000_0005, 8'h0); rd(0);
        cyc(1, 0, 32'hFFFF_FFFF, 8'h0); rd(0);

        // R4: pulse collides with acknowledge
        phase = "R4";
        cyc(0, 0, 0, 8'h08);
        cyc(1, 0, 32'h0000_0008, 8'h08); rd(0);
        cyc(1, 0, 32'hFFFF_FFFF, 8'hFF); rd(0);

        // R5: arm with mixed ones and zeros
        phase = "R5";
        cyc(1, 1, 32'h0000_0003, 8'h0); rd(1);
        cyc(1, 1, 32'h0000_0000, 8'h0); rd(1);
        cyc(1, 1, 32'h8000_0040, 8'h0); rd(1);

        // R6: disarm
        phase = "R6";
        cyc(1, 2, 32'h0000_0000, 8'h0); rd(2);
        cyc(1, 2, 32'h0000_0001, 8'h0); rd(2);

        // R7: both mask addresses agree
        phase = "R7";
        rd(1); rd(2);

        // R10: gate off hides pending armed causes
        phase = "R10";
        cyc(1, 2, 32'h8000_0000, 8'h0);
        rd(0); rd(0);
        cyc(1, 1, 32'h8000_0000, 8'h0);
        rd(0);

        // R9: unimplemented bits, top status bit, unused address
        phase = "R9";
        cyc(1, 1, 32'hFFFF_FFFF, 8'h0); rd(1);
        cyc(1, 3, 32'hFFFF_FFFF, 8'h0); rd(3); rd(2); rd(0);
        cyc(1, 0, 32'hFFFF_FFFF, 8'h0); rd(0);

        // R8: random mix of events, acks, arms and disarms
        phase = "R8";
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] d;
            d = $urandom;
            if ($urandom_range(0, 3) == 0) d = d | 32'h8000_0000;
            cyc(($urandom_range(0, 2) != 0), 2'($urandom_range(0, 3)), d,
                ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h0);
        end
        rd(0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk_i);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule